// File: doc/BRIEF.md
# Quadrature Encoder Counter with Selectable Count Source

This block is a wrapping position or event counter with a 2-bit source selector. In the increment source it adds one on every clock cycle. In the three quadrature sources it decodes two already-synchronized encoder channels, A and B, and counts up or down on their transitions: on A edges only (x2 on A), on B edges only (x2 on B), or on every edge of either channel (x4). The count runs between zero and a programmable ceiling. Stepping past either end wraps to the other end and raises a single-cycle overflow or underflow pulse.

Four word-wide registers sit behind a simple write port and a combinational read port. The control word holds the run bit, the source selector, a ceiling-buffering bit and a self-clearing update strobe. The other three registers are the count, the ceiling and a status word with the direction of the last step. When buffering is on, a new ceiling waits in a shadow register. It becomes active on the next wrap or on an update strobe. The counter suits motor-position feedback, rotary knobs and plain interval timing.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the active and shadow ceilings are all ones, the control word (run bit, source, buffering) is 0, the direction flag is 0 and both wrap pulses are low.
- R2: With source 0 (increment) and the run bit set, the count advances by one on every clock cycle, and the levels and edges of A and B have no effect.
- R3: With source 1 (x2 on A), every rising or falling edge of A is one step, taken upward when A and B differ after the edge and downward when they are equal; an edge of B alone causes no step.
- R4: With source 2 (x2 on B), every edge of B is one step, taken upward when A and B are equal after the edge and downward when they differ; an edge of A alone causes no step.
- R5: With source 3 (x4), an edge on A steps under the R3 direction rule and an edge on B steps under the R4 rule, so the phase order A-rises-while-B-low counts up and the reverse order counts down; a cycle in which both channels change causes no step.
- R6: While the run bit is 0 the count holds its value, and channel edges seen during that time are discarded, not counted later.
- R7: An up step from a count at or above the active ceiling gives 0 together with a one-cycle overflow pulse; a down step from 0 gives the shadow ceiling together with a one-cycle underflow pulse; the two pulses are never high together.
- R8: The direction flag (port and bit 0 of the status register, address 3) becomes 1 after a down step and 0 after an up step, and otherwise keeps its value.
- R9: With buffering off, a write to the ceiling register (address 2) sets the active ceiling from the next cycle on.
- R10: With buffering on, a ceiling write reaches only the shadow register; the active ceiling takes the shadow value on the next wrap, or on a control write with bit 4 (update strobe) set.
- R11: A write to the count register (address 1) loads the count only if the value does not exceed the active ceiling, and is otherwise ignored; an accepted load takes priority over a step in the same cycle.
- R12: The control register at address 0 holds the run bit in bit 0, the source in bits 2:1 (0 increment, 1 x2 on A, 2 x2 on B, 3 x4) and buffering in bit 3; bit 4 is the update strobe and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | W | Register read data, combinational |
| in_a | input | 1 | Encoder channel A, synchronized |
| in_b | input | 1 | Encoder channel B, synchronized |
| count_o | output | W | Current count |
| dir_down_o | output | 1 | Direction of the last step, 1 = down |
| ovf_o | output | 1 | One-cycle pulse on an up wrap |
| unf_o | output | 1 | One-cycle pulse on a down wrap |

## Verification
On every cycle the assertions check that the count holds while stopped, that the wrap pulses are exclusive and land on zero or on the ceiling, that the direction flag follows each step, that the x2 sources ignore the other channel, and that an accepted count load never exceeds the ceiling. The bench's scenarios are needed for the rest. They show the exact count sequence in each source over forward, reverse, single-channel and simultaneous-edge patterns, the moment a buffered ceiling takes effect on a wrap or a strobe, loads above the ceiling being refused, and edges during a stop being discarded. These are checked against a cycle model the bench builds from the requirements.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    QM_INC = 2'd0,
    QM_X2A = 2'd1,
    QM_X2B = 2'd2,
    QM_X4  = 2'd3
  } qenc_mode_e;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_COUNT = 2'd1;
  localparam logic [1:0] RA_CEIL  = 2'd2;
  localparam logic [1:0] RA_STAT  = 2'd3;

  localparam int CB_EN      = 0;
  localparam int CB_MODE_LO = 1;
  localparam int CB_PRE     = 3;
  localparam int CB_UPD     = 4;
  localparam int CTRL_BITS  = 5;

  // Up/down decision for an edge on channel A, levels taken after the edge.
  function automatic logic dir_up_on_a(input logic a, input logic b);
    return a ^ b;
  endfunction

  // Up/down decision for an edge on channel B, levels taken after the edge.
  function automatic logic dir_up_on_b(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

endpackage

// File: rtl/qenc_edge_dec.sv
module qenc_edge_dec
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_a,
  input  logic       in_b,
  input  qenc_mode_e mode,
  output logic       a_edge,
  output logic       b_edge,
  output logic       step,
  output logic       step_up
);

  logic a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  assign a_edge = in_a ^ a_q;
  assign b_edge = in_b ^ b_q;

  always_comb begin
    step    = 1'b0;
    step_up = 1'b1;
    unique case (mode)
      QM_INC: begin
        step    = 1'b1;
        step_up = 1'b1;
      end
      QM_X2A: begin
        step    = a_edge;
        step_up = dir_up_on_a(in_a, in_b);
      end
      QM_X2B: begin
        step    = b_edge;
        step_up = dir_up_on_b(in_a, in_b);
      end
      QM_X4: begin
        // simultaneous change on both channels is not a valid transition
        step    = a_edge ^ b_edge;
        step_up = a_edge ? dir_up_on_a(in_a, in_b) : dir_up_on_b(in_a, in_b);
      end
      default: begin
        step    = 1'b0;
        step_up = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         wrap_evt,
  output logic         en,
  output qenc_mode_e   mode,
  output logic         preload,
  output logic [W-1:0] ceil_act,
  output logic [W-1:0] ceil_shd,
  output logic         cnt_load,
  output logic         ceil_wr,
  output logic         upd_evt
);

  localparam logic [W-1:0] CEIL_RST = '1;

  logic ctrl_wr;

  assign ctrl_wr  = wr_en && (wr_addr == RA_CTRL);
  assign ceil_wr  = wr_en && (wr_addr == RA_CEIL);
  assign upd_evt  = ctrl_wr && wr_data[CB_UPD];
  assign cnt_load = wr_en && (wr_addr == RA_COUNT) && (wr_data <= ceil_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      mode    <= QM_INC;
      preload <= 1'b0;
    end else if (ctrl_wr) begin
      en      <= wr_data[CB_EN];
      mode    <= qenc_mode_e'(wr_data[CB_MODE_LO +: 2]);
      preload <= wr_data[CB_PRE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_shd <= CEIL_RST;
    end else if (ceil_wr) begin
      ceil_shd <= wr_data;
    end
  end

  // A direct write wins over a reload from the shadow in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_act <= CEIL_RST;
    end else if (ceil_wr && !preload) begin
      ceil_act <= wr_data;
    end else if (wrap_evt || upd_evt) begin
      ceil_act <= ceil_shd;
    end
  end

endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         step_up,
  input  logic         cnt_load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] ceil_act,
  input  logic [W-1:0] ceil_shd,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         ovf,
  output logic         unf,
  output logic         wrap_evt
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic [W-1:0] next_up(input logic [W-1:0] c, input logic [W-1:0] lim);
    return (c >= lim) ? ZERO : (c + ONE);
  endfunction

  function automatic logic [W-1:0] next_down(input logic [W-1:0] c, input logic [W-1:0] reload);
    return (c == ZERO) ? reload : (c - ONE);
  endfunction

  logic advance, up_wrap, dn_wrap;

  assign advance  = en && step && !cnt_load;
  assign up_wrap  = advance && step_up && (cnt >= ceil_act);
  assign dn_wrap  = advance && !step_up && (cnt == ZERO);
  assign wrap_evt = up_wrap || dn_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= ZERO;
      dir_down <= 1'b0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      ovf <= up_wrap;
      unf <= dn_wrap;
      if (cnt_load) begin
        cnt <= load_val;
      end else if (advance) begin
        cnt <= step_up ? next_up(cnt, ceil_act) : next_down(cnt, ceil_shd);
      end
      if (advance) begin
        dir_down <= !step_up;
      end
    end
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         in_a,
  input  logic         in_b,
  output logic [W-1:0] count_o,
  output logic         dir_down_o,
  output logic         ovf_o,
  output logic         unf_o
);

  localparam int MIN_W = CTRL_BITS;
  if (W < MIN_W) begin : g_width_check
    $error("qenc_counter: W must hold the control word");
  end

  qenc_mode_e   mode;
  logic         en, preload;
  logic [W-1:0] ceil_act, ceil_shd, cnt;
  logic         cnt_load, ceil_wr, upd_evt, wrap_evt;
  logic         a_edge, b_edge, step, step_up;
  logic         dir_down, ovf, unf;

  qenc_edge_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_a    (in_a),
    .in_b    (in_b),
    .mode    (mode),
    .a_edge  (a_edge),
    .b_edge  (b_edge),
    .step    (step),
    .step_up (step_up)
  );

  qenc_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wrap_evt (wrap_evt),
    .en       (en),
    .mode     (mode),
    .preload  (preload),
    .ceil_act (ceil_act),
    .ceil_shd (ceil_shd),
    .cnt_load (cnt_load),
    .ceil_wr  (ceil_wr),
    .upd_evt  (upd_evt)
  );

  qenc_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step     (step),
    .step_up  (step_up),
    .cnt_load (cnt_load),
    .load_val (wr_data),
    .ceil_act (ceil_act),
    .ceil_shd (ceil_shd),
    .cnt      (cnt),
    .dir_down (dir_down),
    .ovf      (ovf),
    .unf      (unf),
    .wrap_evt (wrap_evt)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_CTRL: begin
        rd_data[CB_EN]              = en;
        rd_data[CB_MODE_LO +: 2]    = mode;
        rd_data[CB_PRE]             = preload;
      end
      RA_COUNT: rd_data = cnt;
      RA_CEIL:  rd_data = ceil_act;
      RA_STAT:  rd_data[0] = dir_down;
      default:  rd_data = '0;
    endcase
  end

  assign count_o    = cnt;
  assign dir_down_o = dir_down;
  assign ovf_o      = ovf;
  assign unf_o      = unf;

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input qenc_mode_e   mode,
  input logic         a_edge,
  input logic         b_edge,
  input logic         step,
  input logic         step_up,
  input logic         cnt_load,
  input logic         ceil_wr,
  input logic [W-1:0] ceil_act,
  input logic [W-1:0] count_o,
  input logic         dir_down_o,
  input logic         ovf_o,
  input logic         unf_o
);

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_load) |=> $stable(count_o)); // R6

  AST_WRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o})); // R7

  AST_OVF_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (count_o == '0)); // R7

  AST_UNF_LANDS_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_o && !$past(ceil_wr)) |-> (count_o == ceil_act)); // R7

  AST_DIR_TRACKS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !cnt_load) |=> (dir_down_o == !$past(step_up))); // R8

  AST_X2A_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == QM_X2A) && !a_edge) |-> !step); // R3

  AST_X2B_IGNORES_A: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == QM_X2B) && !b_edge) |-> !step); // R4

  AST_LOAD_WITHIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (count_o <= $past(ceil_act))); // R11

endmodule

bind qenc_counter qenc_counter_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .mode       (mode),
  .a_edge     (a_edge),
  .b_edge     (b_edge),
  .step       (step),
  .step_up    (step_up),
  .cnt_load   (cnt_load),
  .ceil_wr    (ceil_wr),
  .ceil_act   (ceil_act),
  .count_o    (count_o),
  .dir_down_o (dir_down_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/qenc_counter_tb.sv
`timescale 1ns/1ps
module qenc_counter_tb;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [BW-1:0] rd_data;
  logic          in_a = 1'b0;
  logic          in_b = 1'b0;
  logic [BW-1:0] count_o;
  logic          dir_down_o, ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  qenc_counter #(.W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .in_a(in_a), .in_b(in_b),
    .count_o(count_o), .dir_down_o(dir_down_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // Cycle model written from the requirements.
  logic [BW-1:0] m_cnt, m_act, m_shd;
  logic [1:0]    m_mode;
  logic          m_en, m_pre, m_dir, m_ovf, m_unf, m_pa, m_pb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_act <= '1; m_shd <= '1; m_mode <= 2'd0;
      m_en <= 1'b0; m_pre <= 1'b0; m_dir <= 1'b0; m_ovf <= 1'b0; m_unf <= 1'b0;
      m_pa <= 1'b0; m_pb <= 1'b0;
    end else begin : mdl
      logic ae, be, st, up, ld, cw, upd, adv, wu, wd;
      ae = (in_a != m_pa);
      be = (in_b != m_pb);
      case (m_mode)
        2'd0: begin st = 1'b1; up = 1'b1; end
        2'd1: begin st = ae; up = (in_a != in_b); end
        2'd2: begin st = be; up = (in_a == in_b); end
        default: begin st = ae ^ be; up = ae ? (in_a != in_b) : (in_a == in_b); end
      endcase
      ld  = wr_en && (wr_addr == 2'd1) && (wr_data <= m_act);
      cw  = wr_en && (wr_addr == 2'd2);
      upd = wr_en && (wr_addr == 2'd0) && wr_data[4];
      adv = m_en && st && !ld;
      wu  = adv && up && (m_cnt >= m_act);
      wd  = adv && !up && (m_cnt == '0);
      m_ovf <= wu;
      m_unf <= wd;
      if (ld) m_cnt <= wr_data;
      else if (adv) m_cnt <= up ? (wu ? '0 : m_cnt + 1'b1) : (wd ? m_shd : m_cnt - 1'b1);
      if (adv) m_dir <= !up;
      if (cw && !m_pre) m_act <= wr_data;
      else if (wu || wd || upd) m_act <= m_shd;
      if (cw) m_shd <= wr_data;
      if (wr_en && (wr_addr == 2'd0)) begin
        m_en <= wr_data[0]; m_mode <= wr_data[2:1]; m_pre <= wr_data[3];
      end
      m_pa <= in_a;
      m_pb <= in_b;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      chk(cur_req, "count", 32'(count_o), 32'(m_cnt));
      chk("R8", "direction", 32'(dir_down_o), 32'(m_dir));
      chk("R7", "overflow pulse", 32'(ovf_o), 32'(m_ovf));
      chk("R7", "underflow pulse", 32'(unf_o), 32'(m_unf));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [BW-1:0] v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    in_a = a; in_b = b;
    @(negedge clk);
  endtask

  function automatic int pos_of(input logic a, input logic b);
    return a ? (b ? 2 : 1) : (b ? 3 : 0);
  endfunction

  task automatic walk(input int n, input bit fwd);
    int p;
    p = pos_of(in_a, in_b);
    for (int i = 0; i < n; i++) begin
      p = fwd ? (p + 1) % 4 : (p + 3) % 4;
      drive(p == 1 || p == 2, p >= 2);
    end
  endtask

  initial begin
    logic [BW-1:0] v, prev, held;
    logic [BW-1:0] ctl;
    repeat (4) @(negedge clk);
    // R1: reset state observed while reset is still applied and after release
    rd(2'd0, v); chk("R1", "ctrl", 32'(v), 0);
    rd(2'd1, v); chk("R1", "count", 32'(v), 0);
    rd(2'd2, v); chk("R1", "ceiling", 32'(v), 32'hFF);
    rd(2'd3, v); chk("R1", "status", 32'(v), 0);
    chk("R1", "pulses", 32'({ovf_o, unf_o}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    for (int mode = 0; mode < 4; mode++) begin
      for (int pre = 0; pre < 2; pre++) begin
        cur_req = (mode == 0) ? "R2" : (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R5";
        ctl = BW'((pre << 3) | (mode << 1));
        wr(2'd0, ctl);
        rd(2'd0, v); chk("R12", "ctrl readback", 32'(v), 32'(ctl));
        rd(2'd2, prev);
        wr(2'd2, BW'(5 + pre));
        rd(2'd2, v);
        if (pre == 0) begin
          chk("R9", "ceiling live", 32'(v), 32'(5));
        end else begin
          chk("R10", "ceiling held in shadow", 32'(v), 32'(prev));
          wr(2'd0, ctl | 8'h10);
          rd(2'd2, v); chk("R10", "ceiling after update strobe", 32'(v), 32'(6));
          rd(2'd0, v); chk("R12", "strobe reads zero", 32'(v), 32'(ctl));
        end
        // R11: over-ceiling load refused, in-range load accepted
        rd(2'd1, held);
        wr(2'd1, 8'd200);
        rd(2'd1, v); chk("R11", "load above ceiling ignored", 32'(v), 32'(held));
        wr(2'd1, 8'd2);
        rd(2'd1, v); chk("R11", "load accepted", 32'(v), 32'(2));

        wr(2'd0, ctl | 8'h01);
        if (mode == 0) begin
          drive(1'b1, 1'b0); drive(1'b0, 1'b1);
          repeat (8) @(negedge clk);
          if (pre == 1) wr(2'd2, 8'd3);
          repeat (10) @(negedge clk);
        end else begin
          walk(13, 1'b1);
          if (pre == 1) wr(2'd2, 8'd3);
          walk(14, 1'b1);
          walk(31, 1'b0);
          for (int i = 0; i < 5; i++) drive(in_a, ~in_b);
          for (int i = 0; i < 5; i++) drive(~in_a, in_b);
          for (int i = 0; i < 3; i++) drive(~in_a, ~in_b);
          walk(6, 1'b0);
        end

        // R6: stop, wiggle the channels, confirm the count is frozen and stays so
        wr(2'd0, ctl);
        rd(2'd1, held);
        for (int i = 0; i < 4; i++) drive(~in_a, in_b);
        for (int i = 0; i < 3; i++) drive(in_a, ~in_b);
        rd(2'd1, v); chk("R6", "frozen while stopped", 32'(v), 32'(held));
        if (mode != 0) begin
          wr(2'd0, ctl | 8'h01);
          repeat (3) @(negedge clk);
          rd(2'd1, v); chk("R6", "stopped edges discarded", 32'(v), 32'(held));
          wr(2'd0, ctl);
        end
        rd(2'd3, v); chk("R8", "status register", 32'(v), 32'(m_dir));
        // restore a full live ceiling for the next pass
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFF);
      end
    end

    mon_on = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule